// File: doc/BRIEF.md
# Saturating 64-bit Accumulator Update Unit

This unit keeps a small bank of signed 64-bit accumulators. Each one is stored as an upper and a lower 32-bit half. A caller presents an update: an accumulator index, a signed 64-bit operand (usually a fractional product made elsewhere), and an add/subtract choice. In one clock cycle the unit reads the chosen accumulator and combines it with the operand. It detects signed overflow with a separate equation for each direction, clamps the result to the nearest 64-bit limit when overflow occurs, and writes both halves back.

Each accumulator has a sticky overflow bit in a 32-bit control word, at bit position 16 plus the accumulator index. A bit is set whenever its accumulator saturates and stays set until reset. A direct load path can write either half of any accumulator, for test and initialisation. Any accumulator can be read back through a separate read port.

The update input uses a valid/ready handshake. `upd_ready` is low in any cycle in which a direct load is requested. An update is applied only in a cycle where both `upd_valid` and `upd_ready` are high. The caller must hold its update until it sees ready.

Top module: `sat_acc_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears every accumulator half to 0 and every bit of `ctrl_flags` to 0.
- R2: An accepted update with `upd_sub`=0 writes acc + operand (two's complement, 64 bits) into the selected accumulator when no overflow occurs. The value reads back on `{rd_hi, rd_lo}` one cycle after the accepting edge, with carries crossing the 32-bit half boundary.
- R3: An accepted update with `upd_sub`=1 writes acc - operand when no overflow occurs.
- R4: Add overflow occurs when the operand and the accumulator have equal sign bits (bit 63) and the wrapped sum has a different sign bit. On overflow, a wrapped result with bit 63 = 1 becomes 0x7FFF_FFFF_FFFF_FFFF, and one with bit 63 = 0 becomes 0x8000_0000_0000_0000.
- R5: Subtract overflow occurs when the sign bits of accumulator and operand differ and the wrapped difference's sign bit differs from the accumulator's. The clamp follows the same rule as R4. For example, 0 - 0x8000_0000_0000_0000 gives 0x7FFF_FFFF_FFFF_FFFF with overflow, and 0x8000_0000_0000_0000 - 0x8000_0000_0000_0000 gives 0 without overflow.
- R6: On an accepted update that overflows, bit (16 + index) of `ctrl_flags` becomes 1. These bits never clear except by reset. All bits outside 16..19 always read 0.
- R7: An update changes only the selected accumulator. The other three keep their values.
- R8: `ld_hi_en` writes `ld_data` into the upper half of accumulator `ld_idx`, and `ld_lo_en` writes it into the lower half. The other half of that accumulator keeps its value.
- R9: `upd_ready` is 0 in any cycle where `ld_hi_en` or `ld_lo_en` is 1. An update offered in such a cycle changes no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request present |
| upd_ready | output | 1 | Update can be taken this cycle |
| upd_idx | input | 2 | Accumulator selected for the update |
| upd_sub | input | 1 | 0 = add operand, 1 = subtract operand |
| upd_operand | input | 64 | Signed 64-bit operand |
| ld_hi_en | input | 1 | Load upper half directly |
| ld_lo_en | input | 1 | Load lower half directly |
| ld_idx | input | 2 | Accumulator selected for a direct load |
| ld_data | input | 32 | Data for a direct load |
| rd_idx | input | 2 | Accumulator shown on the read port |
| rd_hi | output | 32 | Upper half of accumulator `rd_idx` |
| rd_lo | output | 32 | Lower half of accumulator `rd_idx` |
| ctrl_flags | output | 32 | Control word with sticky overflow bits 16..19 |

## Verification
The properties assume that reset is held for at least one rising edge before operation, so every history term starts from cleared state. They also assume that inputs are known whenever a valid or load enable is high. The write-back properties only engage when the read index points at the accumulator just written. The stimulus therefore keeps `rd_idx` on the target accumulator during each update and load. Loads and updates are driven on falling edges and held for exactly one cycle. The one deliberate collision, a load and an update in the same cycle, is the back-pressure case of R9.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } acc_op_e;

  // Signed overflow from sign bits of operand a, operand b and wrapped result r.
  function automatic logic sign_overflow(input logic sa, input logic sb,
                                         input logic sr, input acc_op_e op);
    if (op == OP_ADD)
      return ~(sa ^ sb) & (sa ^ sr);
    else
      return (sa ^ sb) & (sa ^ sr);
  endfunction

endpackage

// File: rtl/sat_acc_alu.sv
module sat_acc_alu
  import sat_acc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  acc_op_e      op,
  output logic [W-1:0] result,
  output logic         ovf
);

  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] wrapped;

  always_comb begin
    if (op == OP_SUB) wrapped = acc - operand;
    else              wrapped = acc + operand;
    ovf = sign_overflow(acc[W-1], operand[W-1], wrapped[W-1], op);
    if (!ovf)              result = wrapped;
    else if (wrapped[W-1]) result = POS_LIMIT;
    else                   result = NEG_LIMIT;
  end

endmodule

// File: rtl/sat_acc_bank.sv
module sat_acc_bank #(
  parameter int NUM_ACC = 4,
  parameter int HALF_W  = 32,
  localparam int IDX_W  = $clog2(NUM_ACC),
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FULL_W-1:0] wr_val,
  input  logic              ld_hi_en,
  input  logic              ld_lo_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [HALF_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  op_idx,
  output logic [FULL_W-1:0] op_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HALF_W-1:0] rd_hi,
  output logic [HALF_W-1:0] rd_lo
);

  logic [HALF_W-1:0] hi_q [NUM_ACC];
  logic [HALF_W-1:0] lo_q [NUM_ACC];

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_entry
    logic upd_here, ldh_here, ldl_here;
    assign upd_here = wr_en    && (wr_idx == IDX_W'(i));
    assign ldh_here = ld_hi_en && (ld_idx == IDX_W'(i));
    assign ldl_here = ld_lo_en && (ld_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end else begin
        if (upd_here)      hi_q[i] <= wr_val[FULL_W-1:HALF_W];
        else if (ldh_here) hi_q[i] <= ld_data;
        if (upd_here)      lo_q[i] <= wr_val[HALF_W-1:0];
        else if (ldl_here) lo_q[i] <= ld_data;
      end
    end
  end

  assign op_val = {hi_q[op_idx], lo_q[op_idx]};
  assign rd_hi  = hi_q[rd_idx];
  assign rd_lo  = lo_q[rd_idx];

endmodule

// File: rtl/sat_acc_flags.sv
module sat_acc_flags #(
  parameter int NUM_ACC   = 4,
  parameter int FLAG_BASE = 16,
  parameter int CTRL_W    = 32,
  localparam int IDX_W    = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  output logic [CTRL_W-1:0] ctrl
);

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b >= FLAG_BASE && b < FLAG_BASE + NUM_ACC) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= 1'b0;
        else if (set_en && set_idx == IDX_W'(b - FLAG_BASE))
          q <= 1'b1;
      end
      assign ctrl[b] = q;
    end else begin : g_zero
      assign ctrl[b] = 1'b0;
    end
  end

endmodule

// File: rtl/sat_acc_unit.sv
module sat_acc_unit
  import sat_acc_pkg::*;
#(
  parameter int NUM_ACC   = 4,
  parameter int HALF_W    = 32,
  parameter int FLAG_BASE = 16,
  parameter int CTRL_W    = 32,
  localparam int IDX_W    = $clog2(NUM_ACC),
  localparam int FULL_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_sub,
  input  logic [FULL_W-1:0] upd_operand,
  input  logic              ld_hi_en,
  input  logic              ld_lo_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [HALF_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HALF_W-1:0] rd_hi,
  output logic [HALF_W-1:0] rd_lo,
  output logic [CTRL_W-1:0] ctrl_flags
);

  logic              upd_fire;
  logic [FULL_W-1:0] acc_cur;
  logic [FULL_W-1:0] alu_res;
  logic              alu_ovf;
  acc_op_e           op_sel;

  // Direct loads take the cycle; updates wait.
  assign upd_ready = !(ld_hi_en || ld_lo_en);
  assign upd_fire  = upd_valid && upd_ready;
  assign op_sel    = upd_sub ? OP_SUB : OP_ADD;

  sat_acc_bank #(.NUM_ACC(NUM_ACC), .HALF_W(HALF_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (upd_fire),
    .wr_idx  (upd_idx),
    .wr_val  (alu_res),
    .ld_hi_en(ld_hi_en),
    .ld_lo_en(ld_lo_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .op_idx  (upd_idx),
    .op_val  (acc_cur),
    .rd_idx  (rd_idx),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo)
  );

  sat_acc_alu #(.W(FULL_W)) u_alu (
    .acc    (acc_cur),
    .operand(upd_operand),
    .op     (op_sel),
    .result (alu_res),
    .ovf    (alu_ovf)
  );

  sat_acc_flags #(.NUM_ACC(NUM_ACC), .FLAG_BASE(FLAG_BASE), .CTRL_W(CTRL_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (upd_fire && alu_ovf),
    .set_idx(upd_idx),
    .ctrl   (ctrl_flags)
  );

endmodule

// File: rtl/sat_acc_chk.sv
module sat_acc_chk #(
  parameter int NUM_ACC   = 4,
  parameter int HALF_W    = 32,
  parameter int FLAG_BASE = 16,
  parameter int CTRL_W    = 32,
  localparam int IDX_W    = $clog2(NUM_ACC),
  localparam int FULL_W   = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [IDX_W-1:0]  upd_idx,
  input logic              ld_hi_en,
  input logic              ld_lo_en,
  input logic [IDX_W-1:0]  ld_idx,
  input logic [HALF_W-1:0] ld_data,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [HALF_W-1:0] rd_hi,
  input logic [HALF_W-1:0] rd_lo,
  input logic [CTRL_W-1:0] ctrl_flags,
  input logic [FULL_W-1:0] alu_res,
  input logic              alu_ovf
);

  localparam logic [CTRL_W-1:0] FLAG_MASK = CTRL_W'(((1 << NUM_ACC) - 1) << FLAG_BASE);
  localparam logic [FULL_W-1:0] POS_LIMIT = {1'b0, {(FULL_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] NEG_LIMIT = {1'b1, {(FULL_W-1){1'b0}}};

  logic fire;
  assign fire = upd_valid && upd_ready;

  AST_FLAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_flags & ~FLAG_MASK) == '0); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_flags & $past(ctrl_flags)) == $past(ctrl_flags)); // R6

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && alu_ovf) |=> ctrl_flags[FLAG_BASE + int'($past(upd_idx))]); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ctrl_flags)); // R9

  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ovf |-> (alu_res == POS_LIMIT || alu_res == NEG_LIMIT)); // R4

  AST_UPD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire ##1 (rd_idx == $past(upd_idx)) |-> {rd_hi, rd_lo} == $past(alu_res)); // R2

  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi_en ##1 (rd_idx == $past(ld_idx)) |-> rd_hi == $past(ld_data)); // R8

  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_en ##1 (rd_idx == $past(ld_idx)) |-> rd_lo == $past(ld_data)); // R8

endmodule

bind sat_acc_unit sat_acc_chk #(
  .NUM_ACC(NUM_ACC), .HALF_W(HALF_W), .FLAG_BASE(FLAG_BASE), .CTRL_W(CTRL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .upd_idx   (upd_idx),
  .ld_hi_en  (ld_hi_en),
  .ld_lo_en  (ld_lo_en),
  .ld_idx    (ld_idx),
  .ld_data   (ld_data),
  .rd_idx    (rd_idx),
  .rd_hi     (rd_hi),
  .rd_lo     (rd_lo),
  .ctrl_flags(ctrl_flags),
  .alu_res   (alu_res),
  .alu_ovf   (alu_ovf)
);

// File: tb/tb_sat_acc_unit.sv
`timescale 1ns/1ps
module tb_sat_acc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid, upd_ready, upd_sub;
  logic [1:0]  upd_idx, ld_idx, rd_idx;
  logic [63:0] upd_operand;
  logic        ld_hi_en, ld_lo_en;
  logic [31:0] ld_data, rd_hi, rd_lo, ctrl_flags;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_flags;

  always #2.5 clk = ~clk;

  sat_acc_unit dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_idx(upd_idx), .upd_sub(upd_sub), .upd_operand(upd_operand),
    .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_lo(rd_lo), .ctrl_flags(ctrl_flags)
  );

  localparam int NV = 11;
  localparam logic [63:0] V_ACC [NV] = '{
    64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFF0,
    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0006_6666,
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_OPD [NV] = '{
    64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0020,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h0000_0000_0005_5555,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
    64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000_0001_FFFF_FFFF, 64'h0000_0001_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0001_1111,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [1:0] V_IDX [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1};
  localparam logic       V_SUB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic       V_OVF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_acc(input logic [1:0] idx, input logic [63:0] val);
    @(negedge clk);
    ld_idx = idx; ld_hi_en = 1'b1; ld_data = val[63:32];
    @(negedge clk);
    ld_hi_en = 1'b0; ld_lo_en = 1'b1; ld_data = val[31:0];
    @(negedge clk);
    ld_lo_en = 1'b0;
  endtask

  task automatic do_update(input logic [1:0] idx, input logic sub, input logic [63:0] opd);
    rd_idx = idx;
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = idx; upd_sub = sub; upd_operand = opd;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  function automatic logic [63:0] rd_full();
    return {rd_hi, rd_lo};
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_flags = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    upd_valid = 0; upd_idx = 0; upd_sub = 0; upd_operand = '0;
    ld_hi_en = 0; ld_lo_en = 0; ld_idx = 0; ld_data = '0; rd_idx = 0;
    rst_n = 1'b0;
    reset_dut();

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i); #0.1;
      check("R1 acc clear", rd_full(), 64'd0);
    end
    check("R1 flags clear", {32'd0, ctrl_flags}, 64'd0);
    check("R9 ready idle", {63'd0, upd_ready}, 64'd1);

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      rd_idx = V_IDX[v];
      load_acc(V_IDX[v], V_ACC[v]);
      #0.1;
      check("R8 preload", rd_full(), V_ACC[v]);
      do_update(V_IDX[v], V_SUB[v], V_OPD[v]);
      #0.1;
      if (V_OVF[v]) exp_flags[16 + int'(V_IDX[v])] = 1'b1;
      if (V_OVF[v])       check(V_SUB[v] ? "R5 sub sat" : "R4 add sat", rd_full(), V_EXP[v]);
      else if (V_SUB[v])  check("R3 sub", rd_full(), V_EXP[v]);
      else                check("R2 add", rd_full(), V_EXP[v]);
      check("R6 flags", {32'd0, ctrl_flags}, {32'd0, exp_flags});
    end

    // R7: other accumulators untouched
    reset_dut();
    load_acc(2'd0, 64'h1111_2222_3333_4444);
    load_acc(2'd3, 64'h5555_6666_7777_8888);
    do_update(2'd2, 1'b0, 64'h0000_0000_0000_0005);
    #0.1;
    check("R7 target updated", rd_full(), 64'd5);
    rd_idx = 2'd0; #0.1;
    check("R7 acc0 unchanged", rd_full(), 64'h1111_2222_3333_4444);
    rd_idx = 2'd3; #0.1;
    check("R7 acc3 unchanged", rd_full(), 64'h5555_6666_7777_8888);
    rd_idx = 2'd1; #0.1;
    check("R7 acc1 unchanged", rd_full(), 64'd0);

    // R8: half load keeps the other half
    rd_idx = 2'd3;
    @(negedge clk);
    ld_idx = 2'd3; ld_lo_en = 1'b1; ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ld_lo_en = 1'b0; #0.1;
    check("R8 lo only", rd_full(), 64'h5555_6666_DEAD_BEEF);

    // R9: update offered during a load is refused
    rd_idx = 2'd0;
    @(negedge clk);
    ld_idx = 2'd1; ld_hi_en = 1'b1; ld_data = 32'h0000_00AA;
    upd_valid = 1'b1; upd_idx = 2'd0; upd_sub = 1'b0; upd_operand = 64'h7FFF_FFFF_FFFF_FFFF;
    #0.1;
    check("R9 ready low", {63'd0, upd_ready}, 64'd0);
    @(negedge clk);
    upd_valid = 1'b0; ld_hi_en = 1'b0; #0.1;
    check("R9 acc unchanged", rd_full(), 64'h1111_2222_3333_4444);
    check("R9 flags unchanged", {32'd0, ctrl_flags}, 64'd0);
    rd_idx = 2'd1; #0.1;
    check("R8 hi only", rd_full(), 64'h0000_00AA_0000_0000);

    // R1: reset in mid-run clears values and flags
    do_update(2'd0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
    #0.1;
    check("R4 pos clamp", rd_full(), 64'h7FFF_FFFF_FFFF_FFFF);
    check("R6 flag0", {32'd0, ctrl_flags}, 64'h0000_0000_0001_0000);
    reset_dut();
    rd_idx = 2'd0; #0.1;
    check("R1 acc after reset", rd_full(), 64'd0);
    check("R1 flags after reset", {32'd0, ctrl_flags}, 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule